// File: doc/BRIEF.md
# Core Rope Word Memory Read Sequencer

This block is a synthesizable behavioural model of a read-only rope memory in which one magnetic core stands for a whole word. A word's bits are fixed when the rope is wired. Each data wire either threads the core, which reads as 1, or is routed around it, which reads as 0. The memory is split into several identical modules. The upper address bits pick a module and the lower bits pick a core inside it.

A read is a timed sequence, not an array lookup. A request is accepted only while the sequencer is idle. In the first phase the sequencer drives a pair of inhibit lines for every core-address bit so that every core except the addressed one is held off. At the same time it pulses the set line of the selected module, which sets only the addressed core. In the second phase it pulses that module's reset line. The single set core flips back, and the data wires threading it induce the sense pattern. The sequencer collects that pattern and presents it for one cycle with a valid strobe.

The drive lines are also brought out to ports, so that the phase sequence can be observed.

Top module: `rope_rom`

## Requirements
- R1: After reset, `rd_valid` is 0 and `inh_pos`, `inh_neg`, `set_drv` and `rst_drv` are all zero.
- R2: The word read from full address A (module select in the top bits, core index in the low bits) has bit j equal to 1 exactly when data wire j threads core A. The wiring rule is: bit j is the XOR-reduction of A AND ((j*37+5) mod 2^AW). Address 0 therefore reads as all zeros.
- R3: During the set phase, `inh_pos` equals the core index and `inh_neg` equals its bitwise complement, so only the addressed core has no active inhibit line. Outside the set phase both buses are zero.
- R4: The set phase lasts SET_CYC cycles. During it, `set_drv` has exactly one bit set: bit m, where m is the module select. `rst_drv` is zero throughout.
- R5: The reset/sense phase follows directly and lasts RST_CYC cycles. During it, `rst_drv` has only bit m set, and `set_drv`, `inh_pos` and `inh_neg` are zero. A reset pulse only ever follows a set pulse.
- R6: If a request is sampled at clock edge n, `rd_valid` is high for exactly one cycle, starting at edge n+SET_CYC+RST_CYC, and `rd_data` carries the word.
- R7: A request presented while a read is in progress, including the cycle in which `rd_valid` is high, is ignored. It produces no extra `rd_valid` and does not change the word being read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request, sampled only when idle |
| rd_addr | input | AW (11) | Word address: module select in the top bits, core index in the low bits |
| rd_valid | output | 1 | One-cycle strobe marking the returned word |
| rd_data | output | DATA_W (128) | Sensed word |
| inh_pos | output | CAW (9) | True inhibit line per core-address bit |
| inh_neg | output | CAW (9) | Complement inhibit line per core-address bit |
| set_drv | output | NUM_MOD (4) | Set pulse per module |
| rst_drv | output | NUM_MOD (4) | Reset/sense pulse per module |

## Verification
The embedded properties check every cycle that:
- at most one module's set line is active;
- the inhibit pair is complementary whenever set is driven;
- set and reset never overlap;
- a reset pulse only starts when a core has been set;
- the valid strobe lasts a single cycle.

The bench's scenarios cover the rest:
- the actual sensed words against the wiring rule, including all-zero and all-ones addresses;
- the exact phase lengths and response latency;
- that requests arriving mid-read or during the valid cycle are dropped.

// File: rtl/rope_pkg.sv
package rope_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_INH_SET   = 2'd1,
        ST_RST_SENSE = 2'd2,
        ST_DONE      = 2'd3
    } rope_state_e;
endpackage

// File: rtl/rope_core_plane.sv
module rope_core_plane #(
    parameter int DATA_W  = 128,
    parameter int CAW     = 9,
    parameter int MW      = 2,
    parameter int MOD_ID  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CAW-1:0]    inh_pos,
    input  logic [CAW-1:0]    inh_neg,
    input  logic              set_line,
    input  logic              rst_line,
    output logic [DATA_W-1:0] sense
);
    localparam int AW = CAW + MW;

    typedef struct packed {
        logic           core_set;
        logic [CAW-1:0] idx;
    } plane_t;

    plane_t q, d;

    // Threading rule of the rope: data wire j passes through core a when the
    // masked address has odd parity.
    function automatic logic [DATA_W-1:0] threaded(input logic [AW-1:0] a);
        logic [DATA_W-1:0] w;
        logic [AW-1:0]     mask;
        w = '0;
        for (int j = 0; j < DATA_W; j++) begin
            mask = AW'(j * 37 + 5);
            w[j] = ^(a & mask);
        end
        return w;
    endfunction

    logic [MW-1:0] mod_tag;
    assign mod_tag = MW'(MOD_ID);

    always_comb begin
        d = q;
        // Only the core with no active inhibit line is set: exactly one exists
        // when each true/complement pair disagrees.
        if (set_line && (&(inh_pos ^ inh_neg))) begin
            d.core_set = 1'b1;
            d.idx      = inh_pos;
        end
        if (rst_line && q.core_set) begin
            d.core_set = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // The flip back induces current on every threading wire.
    assign sense = (rst_line && q.core_set) ? threaded({mod_tag, q.idx}) : '0;

    // R5
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_line && rst_line));

    // R5
    rst_after_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_line) |-> q.core_set);
endmodule

// File: rtl/rope_read_seq.sv
module rope_read_seq
    import rope_pkg::*;
#(
    parameter int DATA_W  = 128,
    parameter int CAW     = 9,
    parameter int MW      = 2,
    parameter int NUM_MOD = 4,
    parameter int SET_CYC = 2,
    parameter int RST_CYC = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_req,
    input  logic [CAW+MW-1:0]     rd_addr,
    input  logic [DATA_W-1:0]     sense,
    output logic                  rd_valid,
    output logic [DATA_W-1:0]     rd_data,
    output logic [CAW-1:0]        inh_pos,
    output logic [CAW-1:0]        inh_neg,
    output logic [NUM_MOD-1:0]    set_drv,
    output logic [NUM_MOD-1:0]    rst_drv
);
    localparam int AW   = CAW + MW;
    localparam int MAXC = (SET_CYC > RST_CYC) ? SET_CYC : RST_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        rope_state_e       st;
        logic [CW-1:0]     cnt;
        logic [AW-1:0]     addr;
        logic [DATA_W-1:0] data;
    } seq_t;

    seq_t q, d;

    logic [MW-1:0]  mod_q;
    logic [CAW-1:0] core_q;
    assign mod_q  = q.addr[AW-1 -: MW];
    assign core_q = q.addr[CAW-1:0];

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (rd_req) begin
                    d.st   = ST_INH_SET;
                    d.cnt  = '0;
                    d.addr = rd_addr;
                end
            end
            ST_INH_SET: begin
                if (q.cnt == CW'(SET_CYC - 1)) begin
                    d.st   = ST_RST_SENSE;
                    d.cnt  = '0;
                    d.data = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_RST_SENSE: begin
                d.data = q.data | sense;
                if (q.cnt == CW'(RST_CYC - 1)) begin
                    d.st  = ST_DONE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign inh_pos  = (q.st == ST_INH_SET) ? core_q  : '0;
    assign inh_neg  = (q.st == ST_INH_SET) ? ~core_q : '0;
    assign set_drv  = (q.st == ST_INH_SET)   ? (NUM_MOD'(1) << mod_q) : '0;
    assign rst_drv  = (q.st == ST_RST_SENSE) ? (NUM_MOD'(1) << mod_q) : '0;
    assign rd_valid = (q.st == ST_DONE);
    assign rd_data  = q.data;

    // R4
    set_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_drv));

    // R3
    inh_compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_drv) |-> (&(inh_pos ^ inh_neg)));

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

// File: rtl/rope_rom.sv
module rope_rom #(
    parameter int  DATA_W        = 128,
    parameter int  CORES_PER_MOD = 512,
    parameter int  NUM_MOD       = 4,
    parameter int  SET_CYC       = 2,
    parameter int  RST_CYC       = 3,
    localparam int CAW           = $clog2(CORES_PER_MOD),
    localparam int MW            = $clog2(NUM_MOD),
    localparam int AW            = CAW + MW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_req,
    input  logic [AW-1:0]      rd_addr,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data,
    output logic [CAW-1:0]     inh_pos,
    output logic [CAW-1:0]     inh_neg,
    output logic [NUM_MOD-1:0] set_drv,
    output logic [NUM_MOD-1:0] rst_drv
);
    logic [NUM_MOD-1:0][DATA_W-1:0] sense_mod;
    logic [DATA_W-1:0]              sense_any;

    rope_read_seq #(
        .DATA_W (DATA_W),
        .CAW    (CAW),
        .MW     (MW),
        .NUM_MOD(NUM_MOD),
        .SET_CYC(SET_CYC),
        .RST_CYC(RST_CYC)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (rd_req),
        .rd_addr (rd_addr),
        .sense   (sense_any),
        .rd_valid(rd_valid),
        .rd_data (rd_data),
        .inh_pos (inh_pos),
        .inh_neg (inh_neg),
        .set_drv (set_drv),
        .rst_drv (rst_drv)
    );

    for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
        rope_core_plane #(
            .DATA_W(DATA_W),
            .CAW   (CAW),
            .MW    (MW),
            .MOD_ID(m)
        ) u_plane (
            .clk     (clk),
            .rst_n   (rst_n),
            .inh_pos (inh_pos),
            .inh_neg (inh_neg),
            .set_line(set_drv[m]),
            .rst_line(rst_drv[m]),
            .sense   (sense_mod[m])
        );
    end

    // Sense wires of all modules share the sense amplifiers.
    always_comb begin
        sense_any = '0;
        for (int m = 0; m < NUM_MOD; m++) sense_any = sense_any | sense_mod[m];
    end
endmodule

// File: tb/rope_rom_bench.sv
`timescale 1ns/1ps
module rope_rom_bench;
    localparam int DW  = 128;
    localparam int CPM = 512;
    localparam int NM  = 4;
    localparam int SC  = 2;
    localparam int RC  = 3;
    localparam int CAW = $clog2(CPM);
    localparam int MW  = $clog2(NM);
    localparam int AW  = CAW + MW;

    logic           clk = 0;
    logic           rst_n = 0;
    logic           rd_req = 0;
    logic [AW-1:0]  rd_addr = '0;
    logic           rd_valid;
    logic [DW-1:0]  rd_data;
    logic [CAW-1:0] inh_pos, inh_neg;
    logic [NM-1:0]  set_drv, rst_drv;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [DW-1:0] exp_data[$];
    int            exp_cyc[$];
    logic          prev_valid = 0;
    bit            done = 0;

    rope_rom #(.DATA_W(DW), .CORES_PER_MOD(CPM), .NUM_MOD(NM),
               .SET_CYC(SC), .RST_CYC(RC)) u_rope_rom (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .inh_pos(inh_pos),
        .inh_neg(inh_neg), .set_drv(set_drv), .rst_drv(rst_drv));

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DW-1:0] ref_word(input logic [AW-1:0] a);
        logic [DW-1:0] w;
        for (int j = 0; j < DW; j++) w[j] = ^(a & AW'(j * 37 + 5));
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops scoreboard entries as words come back.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rd_valid) begin
                chk(!prev_valid, "R6 single-cycle valid", DW'(prev_valid), '0);
                if (exp_data.size() == 0) begin
                    chk(0, "R7 unexpected rd_valid", DW'(1), '0);
                end else begin
                    logic [DW-1:0] e;
                    int c;
                    e = exp_data.pop_front();
                    c = exp_cyc.pop_front();
                    chk(rd_data == e, "R2 word data", rd_data, e);
                    chk(cyc - c == SC + RC, "R6 latency", DW'(cyc - c), DW'(SC + RC));
                end
            end
            prev_valid = rd_valid;
        end
    end

    // inject: 0 none, 1 request during set phase, 2 request during valid cycle
    task automatic do_read(input logic [AW-1:0] a, input int inject);
        logic [NM-1:0] onehot;
        onehot = NM'(1) << a[AW-1 -: MW];
        @(negedge clk);
        rd_req = 1; rd_addr = a;
        @(negedge clk);                 // accepting edge has passed
        exp_data.push_back(ref_word(a));
        exp_cyc.push_back(cyc);
        rd_req = (inject == 1); rd_addr = ~a;
        for (int s = 0; s < SC; s++) begin
            chk(inh_pos == a[CAW-1:0], "R3 inh_pos", DW'(inh_pos), DW'(a[CAW-1:0]));
            chk(inh_neg == ~a[CAW-1:0], "R3 inh_neg", DW'(inh_neg), DW'(~a[CAW-1:0]));
            chk(set_drv == onehot && rst_drv == '0, "R4 set line",
                DW'({set_drv, rst_drv}), DW'({onehot, {NM{1'b0}}}));
            @(negedge clk);
        end
        for (int s = 0; s < RC; s++) begin
            chk(rst_drv == onehot && set_drv == '0, "R5 reset line",
                DW'({rst_drv, set_drv}), DW'({onehot, {NM{1'b0}}}));
            chk(inh_pos == '0 && inh_neg == '0, "R3 inhibit idle in reset phase",
                DW'({inh_pos, inh_neg}), '0);
            @(negedge clk);
        end
        // valid cycle
        rd_req = (inject == 2); rd_addr = ~a;
        @(negedge clk);
        rd_req = 0;
        chk(set_drv == '0 && rst_drv == '0 && inh_pos == '0, "R7 no new read after busy req",
            DW'({set_drv, rst_drv, inh_pos}), '0);
        repeat (SC + RC + 2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rd_valid == 0, "R1 rd_valid", DW'(rd_valid), '0);
        chk(inh_pos == 0 && inh_neg == 0, "R1 inhibit", DW'({inh_pos, inh_neg}), '0);
        chk(set_drv == 0 && rst_drv == 0, "R1 set/reset", DW'({set_drv, rst_drv}), '0);
        rst_n = 1;
        @(negedge clk);
        chk(inh_pos == 0 && set_drv == 0, "R3 idle lines", DW'({inh_pos, set_drv}), '0);
        do_read(AW'(0), 0);            // R2 all-zero word
        do_read(AW'(1), 0);
        do_read(AW'(11'h200), 0);      // module 1, core 0
        do_read(AW'(11'h5A5), 1);      // R7 request mid-read
        do_read(AW'(11'h3FF), 2);      // R7 request during valid
        do_read({AW{1'b1}}, 0);        // last core of last module
        do_read(AW'(11'h6C3), 0);
        repeat (5) @(negedge clk);
        chk(exp_data.size() == 0, "R6 all reads returned", DW'(exp_data.size()), '0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule